// File: doc/BRIEF.md
# Masked Pin-Change Interrupt Detector

This block watches a group of general-purpose pins and raises one shared interrupt request when any pin selected by a mask register toggles, in either direction. The pins are read at the pad, so a pin that the chip itself drives as an output still counts. Software can therefore raise the interrupt by toggling such a pin.

Each pin passes through a fixed pipeline before it can reach the interrupt. A latch flop captures the pin. One or more synchroniser flops follow. A compare stage checks the synchronised value against the value from the cycle before. A registered set pulse then sets a sticky flag. The flag stays set until software clears it with a write-one strobe. The request output is the flag gated by a global enable.

A separate unclocked wake output compares the live pins with the latched values under the mask. A sleep controller can use it to detect a toggle while the clock is stopped.

Top module: `pinchg_irq_top`

## Requirements
- R1: After reset the mask and the flag are zero and `irq_o` and `wake_o` are low. On the first clock after reset, every pipeline stage loads the current pin value, so pins that are high at reset cause no flag.
- R2: A pin whose mask bit is 0 never sets the flag and never raises `wake_o`, whatever it does. Bit i of the mask selects pin i.
- R3: A rising edge and a falling edge on an enabled pin each set the flag.
- R4: Let a pin change be captured by the latch at clock edge k. With the default single synchroniser stage, the flag becomes set at edge k+3 and not earlier (in general at k+2+SYNC_STAGES).
- R5: Every pin bit maps to the one shared flag. Several enabled pins that toggle together set that single flag.
- R6: Once set, the flag stays set until `flag_clr_i` is high at a clock edge. That edge clears it.
- R7: If a clear and a set pulse arrive at the same edge, the flag ends up set.
- R8: `irq_o` is high exactly when the flag is set and `pc_en_i` is high. Clearing `pc_en_i` hides the request but keeps the flag.
- R9: `wake_o` is high, with no clock edge needed, while any enabled pin differs from its latched value. It drops once the latch captures the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Pad readback of the watched pins |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | NPINS | Mask register write data, bit i enables pin i |
| flag_clr_i | input | 1 | Write-one clear of the interrupt flag |
| pc_en_i | input | 1 | Global pin-change interrupt enable |
| irq_o | output | 1 | Interrupt request (flag AND enable) |
| wake_o | output | 1 | Unclocked masked change indication for wake-up |

## Verification
The bench builds the block with its defaults: six pins and one synchroniser stage. This exposes the exact three-edge latch-to-flag latency and lets single-pin and multi-pin toggles be mixed across enabled and disabled mask bits. The scoreboard predicts the request output cycle by cycle. That covers the sticky hold, the write-one clear, and a clear timed to land on the same edge as a set pulse. The wake output is sampled between a pin change and the next edge, and again after it, to show that it reacts without a clock.

// File: rtl/pcd_pkg.sv
`timescale 1ns/1ps
package pcd_pkg;

  // Per-bit change test between the synchronised and the previous sample.
  function automatic logic pc_changed(input logic cur, input logic prev);
    return cur ^ prev;
  endfunction

  // Sticky flag update: a set pulse wins over a clear on the same edge.
  function automatic logic pc_sticky_next(input logic flag, input logic set,
                                          input logic clr);
    logic nxt;
    nxt = flag;
    if (clr) nxt = 1'b0;
    if (set) nxt = 1'b1;
    return nxt;
  endfunction

  // Masked difference between live pin value and latched value.
  function automatic logic pc_wake_bit(input logic live, input logic held,
                                       input logic en);
    return en & (live ^ held);
  endfunction

endpackage

// File: rtl/pcd_pin_sync.sv
`timescale 1ns/1ps
module pcd_pin_sync
  import pcd_pkg::*;
#(
  parameter int unsigned NPINS       = 6,
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] lat_o,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] prev_o,
  output logic [NPINS-1:0] chg_o,
  output logic             armed_o
);

  logic armed_q;

  // One cycle after reset the pipeline is seeded from the pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic                   lat_q;
    logic [SYNC_STAGES-1:0] sy_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q  <= 1'b0;
        sy_q   <= '0;
        prev_q <= 1'b0;
      end else if (!armed_q) begin
        lat_q  <= pin_i[p];
        sy_q   <= {SYNC_STAGES{pin_i[p]}};
        prev_q <= pin_i[p];
      end else begin
        lat_q   <= pin_i[p];
        sy_q[0] <= lat_q;
        for (int s = 1; s < SYNC_STAGES; s++) sy_q[s] <= sy_q[s-1];
        prev_q  <= sy_q[SYNC_STAGES-1];
      end
    end

    assign lat_o[p]  = lat_q;
    assign sync_o[p] = sy_q[SYNC_STAGES-1];
    assign prev_o[p] = prev_q;
    assign chg_o[p]  = armed_q & pc_changed(sy_q[SYNC_STAGES-1], prev_q);
  end

  // R1: the seeding cycle leaves no apparent edge behind.
  assert_seed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> (chg_o == '0));

  // R4: the synchroniser output follows the latch one stage later.
  assert_sync_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(armed_q) && SYNC_STAGES == 1) |-> (sync_o == $past(lat_o)));

endmodule

// File: rtl/pcd_wake.sv
`timescale 1ns/1ps
module pcd_wake
  import pcd_pkg::*;
#(
  parameter int unsigned NPINS = 6
) (
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] lat_i,
  input  logic [NPINS-1:0] mask_i,
  output logic             wake_o
);

  logic [NPINS-1:0] diff;

  for (genvar p = 0; p < NPINS; p++) begin : g_cmp
    assign diff[p] = pc_wake_bit(pin_i[p], lat_i[p], mask_i[p]);
  end

  assign wake_o = |diff;

endmodule

// File: rtl/pcd_flag.sv
`timescale 1ns/1ps
module pcd_flag
  import pcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  input  logic en_i,
  output logic setflag_o,
  output logic flag_o,
  output logic irq_o
);

  logic setflag_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setflag_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      setflag_q <= hit_i;
      flag_q    <= pc_sticky_next(flag_q, setflag_q, clr_i);
    end
  end

  assign setflag_o = setflag_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & en_i;

  // R4: the flag only rises one edge after a set pulse.
  assert_flag_after_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(setflag_q));

  // R7: a set pulse always leaves the flag set, clear or not.
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    setflag_q |=> flag_q);

  // R6: a clear with no competing pulse empties the flag.
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !setflag_q) |=> !flag_q);

  // R6: without clear the flag never falls.
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R8: no request while the global enable is low.
  assert_en_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !irq_o);

endmodule

// File: rtl/pinchg_irq_top.sv
`timescale 1ns/1ps
module pinchg_irq_top #(
  parameter int unsigned NPINS       = 6,
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             mask_we_i,
  input  logic [NPINS-1:0] mask_wdata_i,
  input  logic             flag_clr_i,
  input  logic             pc_en_i,
  output logic             irq_o,
  output logic             wake_o
);

  localparam int unsigned LAT_TO_FLAG = SYNC_STAGES + 2;

  logic [NPINS-1:0] mask_q;
  logic [NPINS-1:0] lat_vec, sync_vec, prev_vec, chg_vec;
  logic             armed;
  logic             hit;
  logic             setflag;
  logic             flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  pcd_pin_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .lat_o   (lat_vec),
    .sync_o  (sync_vec),
    .prev_o  (prev_vec),
    .chg_o   (chg_vec),
    .armed_o (armed)
  );

  assign hit = |(chg_vec & mask_q);

  pcd_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit),
    .clr_i     (flag_clr_i),
    .en_i      (pc_en_i),
    .setflag_o (setflag),
    .flag_o    (flag),
    .irq_o     (irq_o)
  );

  pcd_wake #(.NPINS(NPINS)) u_wake (
    .pin_i  (pin_i),
    .lat_i  (lat_vec),
    .mask_i (mask_q),
    .wake_o (wake_o)
  );

  // R2: a set pulse needs a real change from the compare stage the cycle before.
  assert_pulse_needs_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setflag |-> $past(sync_vec != prev_vec));

  // R2: with an empty mask nothing can raise wake.
  assert_wake_needs_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !wake_o);

  // R1: the flag cannot be set before the pipeline has been seeded long enough.
  assert_no_early_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !flag);

  // R4: the latency constant is at least the fixed latch/pulse/flag chain.
  initial assert_latency_shape_R4: assert (LAT_TO_FLAG >= 3);

endmodule

// File: tb/test_pinchg_irq_top.sv
`timescale 1ns/1ps
module test_pinchg_irq_top;

  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = 6'b100101;
  logic          mask_we = 1'b0;
  logic [NP-1:0] mask_wdata = '0;
  logic          flag_clr = 1'b0;
  logic          pc_en = 1'b1;
  logic          irq;
  logic          wake;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic done = 1'b0;

  typedef struct {
    int    at;
    logic  irq;
    string req;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pinchg_irq_top i_pinchg_irq_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_i        (pin),
    .mask_we_i    (mask_we),
    .mask_wdata_i (mask_wdata),
    .flag_clr_i   (flag_clr),
    .pc_en_i      (pc_en),
    .irq_o        (irq),
    .wake_o       (wake)
  );

  task automatic check(input logic act, input logic expv, input string req);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Sorted insert into the scoreboard.
  task automatic push(input int at, input logic v, input string req);
    exp_t e;
    int k;
    e.at = at; e.irq = v; e.req = req;
    k = 0;
    while (k < sb.size() && sb[k].at <= at) k++;
    sb.insert(k, e);
  endtask

  // Monitor: samples 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0 && sb[0].at <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        if (e.at < cyc) begin
          checks++; fails++;
          $display("FAIL %s: missed sample at cycle %0d", e.req, e.at);
        end else begin
          check(irq, e.irq, e.req);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mask(input logic [NP-1:0] m);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic clear_flag(input string req);
    @(negedge clk);
    flag_clr = 1'b1;
    push(cyc + 1, 1'b0, req);
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // Toggle the pins in vec; flag expected at latch edge + 3 (cycle c+4).
  task automatic toggle(input logic [NP-1:0] vec, input logic sets,
                        input logic wake_exp, input string req);
    int c;
    @(negedge clk);
    c = cyc;
    pin = pin ^ vec;
    push(c + 3, 1'b0, {req, " early"});
    push(c + 4, sets & pc_en, req);
    #1;
    check(wake, wake_exp, {req, " wake before edge R9"});
    @(posedge clk);
    #1;
    check(wake, 1'b0, {req, " wake after latch R9"});
    wait_cyc(6);
  endtask

  initial begin
    int c;
    wait_cyc(3);
    check(irq, 1'b0, "R1 irq in reset");
    check(wake, 1'b0, "R1 wake in reset");
    rst_n = 1'b1;
    push(cyc + 2, 1'b0, "R1 no false edge");
    push(cyc + 5, 1'b0, "R1 no false edge later");
    wait_cyc(6);

    // R2: empty mask, toggle pin 3
    toggle(6'b001000, 1'b0, 1'b0, "R2 masked pin");
    set_mask(6'b001111);
    // R2: pin 5 outside the mask
    toggle(6'b100000, 1'b0, 1'b0, "R2 masked pin5");

    // R3/R4 falling edge on pin 0
    toggle(6'b000001, 1'b1, 1'b1, "R3 R4 falling pin0");
    // R6 sticky
    push(cyc + 5, 1'b1, "R6 sticky hold");
    wait_cyc(6);
    clear_flag("R6 clear");
    push(cyc + 3, 1'b0, "R6 stays clear");
    wait_cyc(4);

    // R3 rising edge on pin 1
    toggle(6'b000010, 1'b1, 1'b1, "R3 rising pin1");
    clear_flag("R6 clear2");

    // R5 two pins together, with R8 enable gating
    pc_en = 1'b0;
    toggle(6'b001100, 1'b1, 1'b1, "R8 gated");
    push(cyc + 2, 1'b0, "R8 hidden");
    wait_cyc(3);
    @(negedge clk);
    pc_en = 1'b1;
    push(cyc + 1, 1'b1, "R5 R8 flag kept");
    wait_cyc(3);
    clear_flag("R6 clear3");
    wait_cyc(2);

    // R7 clear on the same edge as the set pulse
    @(negedge clk);
    c = cyc;
    pin = pin ^ 6'b000100;
    wait_cyc(3);
    flag_clr = 1'b1;
    push(c + 4, 1'b1, "R7 set wins");
    @(negedge clk);
    flag_clr = 1'b0;
    wait_cyc(3);
    clear_flag("R6 clear4");
    wait_cyc(4);

    // R2: masked pin after enabling others does nothing while flag clear
    toggle(6'b010000, 1'b0, 1'b0, "R2 masked pin4");
    wait_cyc(4);

    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule